// File: doc/BRIEF.md
# Ladder Logic Scan Engine

This block is a compact programmable controller core. A stored ladder program, a list of rungs, is run once per scan against an internal bit table. When a scan is started, the block copies the input pins into the table. It then evaluates the rungs strictly from first to last, one rung per clock, and writes each rung's result straight back into the table. Finally it copies the output region of the table to the output pins and raises a one-cycle completion pulse.

Each rung is a sum of products. It has up to P terms, and each term has up to K contact slots. Every slot reads one table bit, either as it is (normally open) or inverted (normally closed). The rung's result lands in one coil address. Because results are written back at once, a rung sees the new value of any coil that an earlier rung wrote in the same scan. A coil that reads its own address sees the value it held before this rung, which is what makes seal-in latches work. The program is written through a simple word port while the engine is idle.

Bit table layout, with the defaults ADDR_W=5, N_IN=4 and N_OUT=4: addresses 0..N_IN-1 hold the sampled inputs. Addresses N_IN..N_IN+N_OUT-1 drive the outputs. All higher addresses are internal relays.

Top module: `ladder_scan_engine`

## Requirements
- R1: While rst_ni is low, and after it rises, out_o, scan_done_o and busy_o are 0. The bit table and all program words are cleared.
- R2: A start_scan_i strobe seen while idle samples in_i into table addresses 0..N_IN-1 on that clock edge. Rungs 0..N_RUNGS-1 are then evaluated one per clock. scan_done_o is high for exactly one cycle, N_RUNGS+2 cycles after the cycle in which the strobe was driven. In that same cycle out_o takes table bits N_IN..N_IN+N_OUT-1 (out_o[0] = address N_IN).
- R3: Rung word layout. Bits [ADDR_W-1:0] hold the coil address. Slot j of term t occupies the ADDR_W+2 bits starting at bit ADDR_W+(t*K+j)*(ADDR_W+2). Within a slot, the low ADDR_W bits are the address, the next bit is the negate flag and the top bit is the valid flag. A slot with negate clear returns the addressed bit; a slot with negate set returns its inverse.
- R4: A term is the AND of its valid slots. The rung value is the OR of its terms. A term with no valid slot contributes 0.
- R5: A rung with no valid slot in any term writes nothing. Its coil bit keeps its value.
- R6: Rungs write through in order. A later rung reads a coil written earlier in the same scan with its new value. An earlier rung reads a coil written by a later rung with that coil's value from the previous scan.
- R7: A seal-in rung, coil = (set AND NOT reset) OR (coil AND NOT reset), sets on set, holds after set is released, and clears on reset.
- R8: out_o changes only in the cycle where scan_done_o is high. Between scans it ignores in_i.
- R9: A write with prog_we_i while idle stores prog_data_i at prog_addr_i and is used from the next scan on. A write while busy_o is high leaves the program unchanged.
- R10: start_scan_i while busy_o is high is ignored. The running scan completes with a single scan_done_o pulse and no second scan follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_scan_i | input | 1 | Scan start strobe, honoured only while idle |
| in_i | input | N_IN | Input pins, sampled at scan start |
| out_o | output | N_OUT | Output pins, updated at scan end |
| scan_done_o | output | 1 | One-cycle pulse when outputs are written |
| busy_o | output | 1 | High while a scan is in progress |
| prog_we_i | input | 1 | Program word write enable |
| prog_addr_i | input | IDX_W | Rung index to write |
| prog_data_i | input | WORD_W | Rung encoding |

## Verification
The bench targets ordering. One rung reads a coil written just above it, and another reads a coil written just below it. A design that buffered writes to the end of the scan would lag the first rung by one scan. A design that evaluated all rungs in parallel would remove the lag from the second. A seal-in rung is pulsed set, released and then reset; an engine that read its own coil from a stale copy would drop or stick the latch. An all-empty rung aimed at a live output catches an engine that writes 0 for an empty rung. Program writes and start strobes issued mid-scan must leave the running scan and the stored program untouched. Outputs are sampled mid-scan and between scans to catch early or input-following updates.

// File: rtl/ladder_pkg.sv
package ladder_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_EXEC  = 2'd1,
    PH_WRITE = 2'd2
  } phase_e;
endpackage

// File: rtl/ladder_prog_mem.sv
module ladder_prog_mem #(
  parameter int N_RUNGS = 16,
  parameter int WORD_W  = 47,
  parameter int IDX_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              busy_i,
  input  logic [IDX_W-1:0]  waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [N_RUNGS];
  logic              wr_ok;

  assign wr_ok   = we_i && !busy_i && (int'(waddr_i) < N_RUNGS);
  assign rdata_o = mem_q[raddr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_RUNGS; i++) mem_q[i] <= '0;
    end else if (wr_ok) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  // R9
  busy_wr_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && busy_i && int'(waddr_i) < N_RUNGS) |=> mem_q[$past(waddr_i)] == $past(mem_q[waddr_i]));
  // R9
  idle_wr_stored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !busy_i && int'(waddr_i) < N_RUNGS) |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ladder_rung_eval.sv
module ladder_rung_eval #(
  parameter int ADDR_W = 5,
  parameter int P      = 2,
  parameter int K      = 3,
  localparam int SLOT_W = ADDR_W + 2,
  localparam int WORD_W = ADDR_W + P * K * SLOT_W,
  localparam int TBL_N  = 2 ** ADDR_W
) (
  input  logic [WORD_W-1:0] rung_i,
  input  logic [TBL_N-1:0]  table_i,
  output logic [ADDR_W-1:0] coil_o,
  output logic              val_o,
  output logic              wr_en_o
);
  logic [P-1:0] term_act;
  logic [P-1:0] term_val;

  for (genvar t = 0; t < P; t++) begin : g_term
    logic [K-1:0] vld;
    logic [K-1:0] hit;
    for (genvar j = 0; j < K; j++) begin : g_slot
      logic [SLOT_W-1:0] slot;
      assign slot   = rung_i[ADDR_W + (t*K + j)*SLOT_W +: SLOT_W];
      assign vld[j] = slot[ADDR_W+1];
      // invalid slots are transparent to the AND
      assign hit[j] = !vld[j] || (table_i[slot[ADDR_W-1:0]] ^ slot[ADDR_W]);
    end
    assign term_act[t] = |vld;
    assign term_val[t] = term_act[t] && (&hit);
  end

  assign coil_o  = rung_i[ADDR_W-1:0];
  assign val_o   = |term_val;
  assign wr_en_o = |term_act;
endmodule

// File: rtl/ladder_scan_ctrl.sv
module ladder_scan_ctrl
  import ladder_pkg::*;
#(
  parameter int N_RUNGS = 16,
  localparam int IDX_W  = $clog2(N_RUNGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             sample_o,
  output logic             exec_o,
  output logic             write_o,
  output logic             busy_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_RUNGS - 1);

  phase_e           state_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PH_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        PH_IDLE: if (start_i) begin
          state_q <= PH_EXEC;
          idx_q   <= '0;
        end
        PH_EXEC: begin
          if (idx_q == LAST) state_q <= PH_WRITE;
          else               idx_q   <= idx_q + 1'b1;
        end
        PH_WRITE: state_q <= PH_IDLE;
        default:  state_q <= PH_IDLE;
      endcase
    end
  end

  assign idx_o    = idx_q;
  assign sample_o = (state_q == PH_IDLE) && start_i;
  assign exec_o   = (state_q == PH_EXEC);
  assign write_o  = (state_q == PH_WRITE);
  assign busy_o   = (state_q != PH_IDLE);

  // R2
  exec_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_EXEC && idx_q != LAST) |=> (state_q == PH_EXEC && idx_q == IDX_W'($past(idx_q) + 1'b1)));
  // R2
  exec_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_EXEC && idx_q == LAST) |=> state_q == PH_WRITE);
  // R10
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PH_EXEC && idx_q != LAST && start_i) |=> idx_q != '0);
endmodule

// File: rtl/ladder_scan_engine.sv
module ladder_scan_engine
  import ladder_pkg::*;
#(
  parameter int N_RUNGS = 16,
  parameter int ADDR_W  = 5,
  parameter int P       = 2,
  parameter int K       = 3,
  parameter int N_IN    = 4,
  parameter int N_OUT   = 4,
  localparam int IDX_W  = $clog2(N_RUNGS),
  localparam int SLOT_W = ADDR_W + 2,
  localparam int WORD_W = ADDR_W + P * K * SLOT_W,
  localparam int TBL_N  = 2 ** ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_scan_i,
  input  logic [N_IN-1:0]   in_i,
  output logic [N_OUT-1:0]  out_o,
  output logic              scan_done_o,
  output logic              busy_o,
  input  logic              prog_we_i,
  input  logic [IDX_W-1:0]  prog_addr_i,
  input  logic [WORD_W-1:0] prog_data_i
);
  logic [TBL_N-1:0]  tbl_q;
  logic [IDX_W-1:0]  idx;
  logic              sample, exec, wr_out, busy;
  logic [WORD_W-1:0] rung;
  logic [ADDR_W-1:0] coil;
  logic              coil_val, coil_we;

  ladder_scan_ctrl #(.N_RUNGS(N_RUNGS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_scan_i),
    .idx_o    (idx),
    .sample_o (sample),
    .exec_o   (exec),
    .write_o  (wr_out),
    .busy_o   (busy)
  );

  ladder_prog_mem #(.N_RUNGS(N_RUNGS), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (prog_we_i),
    .busy_i  (busy),
    .waddr_i (prog_addr_i),
    .wdata_i (prog_data_i),
    .raddr_i (idx),
    .rdata_o (rung)
  );

  ladder_rung_eval #(.ADDR_W(ADDR_W), .P(P), .K(K)) u_eval (
    .rung_i  (rung),
    .table_i (tbl_q),
    .coil_o  (coil),
    .val_o   (coil_val),
    .wr_en_o (coil_we)
  );

  // bit table: input sample, then write-through of each rung's coil
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tbl_q <= '0;
    end else if (sample) begin
      tbl_q[N_IN-1:0] <= in_i;
    end else if (exec && coil_we) begin
      tbl_q[coil] <= coil_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_o       <= '0;
      scan_done_o <= 1'b0;
    end else begin
      scan_done_o <= wr_out;
      if (wr_out) out_o <= tbl_q[N_IN +: N_OUT];
    end
  end

  assign busy_o = busy;

  // R8
  out_only_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_o) |-> scan_done_o);
  // R2
  done_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_o |=> !scan_done_o);
  // R2
  input_sample_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample |=> tbl_q[N_IN-1:0] == $past(in_i));
  // R5
  empty_rung_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec && !coil_we) |=> $stable(tbl_q));
endmodule

// File: tb/sim_ladder_scan_engine.sv
`timescale 1ns/1ps
module sim_ladder_scan_engine;
  localparam int NR = 16, AW = 5, P = 2, K = 3, NI = 4, NO = 4;
  localparam int SW = AW + 2, WW = AW + P*K*SW, IW = 4;

  logic          clk = 0, rst_ni = 0, start = 0, we = 0;
  logic [NI-1:0] in_v = '0;
  logic [NO-1:0] out_v;
  logic          done, busy;
  logic [IW-1:0] waddr = '0;
  logic [WW-1:0] wdata = '0;

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [WW-1:0] prog_m [NR];
  logic [31:0]   tbl_m;
  logic [NO-1:0] out_m;

  always #2 clk = ~clk;

  ladder_scan_engine u0 (
    .clk_i(clk), .rst_ni(rst_ni), .start_scan_i(start), .in_i(in_v),
    .out_o(out_v), .scan_done_o(done), .busy_o(busy),
    .prog_we_i(we), .prog_addr_i(waddr), .prog_data_i(wdata));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [WW-1:0] put(logic [WW-1:0] w, int t, int j, bit neg, int a);
    w[AW + (t*K + j)*SW +: SW] = {1'b1, neg, AW'(a)};
    return w;
  endfunction

  function automatic void model_scan(logic [NI-1:0] in);
    tbl_m[NI-1:0] = in;
    for (int r = 0; r < NR; r++) begin
      logic any, v;
      any = 0; v = 0;
      for (int t = 0; t < P; t++) begin
        logic act, tv;
        act = 0; tv = 1;
        for (int j = 0; j < K; j++) begin
          logic [SW-1:0] s;
          s = prog_m[r][AW + (t*K + j)*SW +: SW];
          if (s[SW-1]) begin
            act = 1;
            tv = tv & (tbl_m[s[AW-1:0]] ^ s[AW]);
          end
        end
        if (act) begin any = 1; v = v | tv; end
      end
      if (any) tbl_m[prog_m[r][AW-1:0]] = v;
    end
    out_m = tbl_m[NI +: NO];
  endfunction

  task automatic write_word(int a, logic [WW-1:0] d);
    @(negedge clk);
    we = 1; waddr = IW'(a); wdata = d;
    @(negedge clk);
    we = 0;
  endtask

  // returns after the done cycle has been sampled
  task automatic run_scan(logic [NI-1:0] in, string req);
    int cnt;
    @(negedge clk);
    in_v = in; start = 1;
    @(negedge clk);
    start = 0; cnt = 1;
    while (!done && cnt < 100) begin @(negedge clk); cnt++; end
    model_scan(in);
    chk("R2 scan latency", cnt, NR + 2);
    chk(req, out_v, out_m);
  endtask

  task automatic t_reset();
    chk("R1 out reset", out_v, 0);
    chk("R1 done reset", done, 0);
    chk("R1 busy reset", busy, 0);
    tbl_m = '0; out_m = '0;
  endtask

  task automatic t_load();
    for (int r = 0; r < NR; r++) prog_m[r] = '0;
    prog_m[0] = put(WW'(4), 0, 0, 1, 0);                           // out0 = !in0
    prog_m[1] = put(put(WW'(8), 0, 0, 0, 0), 0, 1, 0, 1);          // b8 = in0 & in1
    prog_m[2] = put(put(WW'(9), 0, 0, 0, 2), 1, 0, 0, 3);          // b9 = in2 | in3
    prog_m[3] = put(put(put(put(WW'(10), 0, 0, 0, 2), 0, 1, 1, 3),
                        1, 0, 0, 10), 1, 1, 1, 3);                 // seal-in b10
    prog_m[4] = put(WW'(5), 0, 0, 0, 8);                           // out1 = b8
    prog_m[5] = put(WW'(6), 0, 0, 0, 10);                          // out2 = b10
    prog_m[6] = put(put(WW'(7), 0, 0, 0, 11), 1, 0, 0, 9);         // out3 = b11 | b9
    prog_m[7] = put(WW'(11), 0, 0, 0, 1);                          // b11 = in1
    prog_m[8] = WW'(4);                                            // empty, coil out0
    for (int r = 0; r < NR; r++) write_word(r, prog_m[r]);
  endtask

  task automatic t_logic();
    logic [NI-1:0] pats [6] = '{4'b0000, 4'b0001, 4'b0011, 4'b0010, 4'b1000, 4'b0100};
    foreach (pats[i]) run_scan(pats[i], "R3 R4 contacts and terms");
    run_scan(4'b0011, "R4 and/or");
    chk("R4 AND term", out_v[1], 1);
    run_scan(4'b0001, "R3 NC contact");
    chk("R3 NC contact", out_v[0], 0);
  endtask

  task automatic t_latch();
    run_scan(4'b1000, "R7 reset first");
    chk("R7 latch clear", out_v[2], 0);
    run_scan(4'b0100, "R7 set");
    chk("R7 latch set", out_v[2], 1);
    run_scan(4'b0000, "R7 hold");
    chk("R7 latch hold", out_v[2], 1);
    run_scan(4'b1000, "R7 reset");
    chk("R7 latch reset", out_v[2], 0);
  endtask

  task automatic t_forward();
    run_scan(4'b0000, "R6 prime");
    run_scan(4'b0011, "R6 forward same scan");
    chk("R6 earlier coil seen now", out_v[1], 1);
    chk("R6 later coil previous scan", out_v[3], 0);
    run_scan(4'b0000, "R6 lag");
    chk("R6 later coil lags", out_v[3], 1);
    chk("R6 earlier coil follows", out_v[1], 0);
  endtask

  task automatic t_nop();
    run_scan(4'b0000, "R5 empty rung");
    chk("R5 empty rung keeps out0", out_v[0], 1);
  endtask

  task automatic t_hold();
    logic [NO-1:0] held;
    held = out_v;
    @(negedge clk); in_v = 4'b1111;
    repeat (10) @(negedge clk);
    chk("R8 hold idle", out_v, held);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    repeat (8) @(negedge clk);
    chk("R8 hold mid-scan", out_v, held);
    while (!done) @(negedge clk);
    model_scan(4'b1111);
    chk("R8 update at done", out_v, out_m);
  endtask

  task automatic t_busy_write();
    logic [WW-1:0] alt;
    alt = put(WW'(4), 0, 0, 0, 0);                                 // out0 = in0
    @(negedge clk); in_v = 4'b0000; start = 1;
    @(negedge clk); start = 0;
    @(negedge clk); we = 1; waddr = '0; wdata = alt;
    @(negedge clk); we = 0;
    while (!done) @(negedge clk);
    model_scan(4'b0000);
    run_scan(4'b0000, "R9 busy write ignored");
    chk("R9 busy write ignored", out_v[0], 1);
    write_word(0, alt); prog_m[0] = alt;
    run_scan(4'b0000, "R9 idle write");
    chk("R9 idle write used", out_v[0], 0);
    prog_m[0] = put(WW'(4), 0, 0, 1, 0);
    write_word(0, prog_m[0]);
  endtask

  task automatic t_busy_start();
    int pulses = 0;
    @(negedge clk); in_v = 4'b0001; start = 1;
    @(negedge clk); start = 0;
    repeat (5) @(negedge clk);
    start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 60; i++) begin
      if (done) pulses++;
      @(negedge clk);
    end
    model_scan(4'b0001);
    chk("R10 one done pulse", pulses, 1);
    chk("R10 idle after", busy, 0);
    chk("R10 result", out_v, out_m);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_logic();
    t_latch();
    t_forward();
    t_nop();
    t_hold();
    t_busy_write();
    t_busy_start();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule